// File: doc/BRIEF.md
# Local Interrupt Timer with Absolute Deadline Mode

This block is the timer of a local interrupt controller. A 64-bit timestamp counter, supplied from outside and advancing by one every clock, drives it. A control register selects one of three modes. In one-shot mode the timer counts a loaded value down once. In periodic mode it counts down and reloads from the initial count after every expiry. In deadline mode it compares a stored absolute 64-bit timestamp against the counter and fires when the counter reaches it.

Software reaches the block through a small synchronous register port with four word addresses. A write takes effect at the clock edge. A read is combinational from the current address. Every expiry that is not masked produces a one-cycle pulse on `irq_valid`, with the 8-bit vector from the control register on `irq_vector`. The registers behave differently in each mode. In deadline mode the count registers read as zero and ignore writes. In the countdown modes the deadline register reads as zero and ignores writes. The deadline register clears itself when it fires.

Top module: `deadline_tick_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq_valid` is low.
- R2: The register map is: address 0 is control, address 1 is initial count, address 2 is current count, address 3 is deadline. In the control register, bits [7:0] hold the vector, bit 16 is the mask and bits [18:17] are the mode (00 one-shot, 01 periodic, 10 deadline). On a control read, all other bits return zero.
- R3: Any write to the control register stops the timer and clears the initial count, the current count and the deadline register to zero. No pulse is produced at that edge.
- R4: In deadline mode, the initial-count and current-count registers read zero, and writes to the initial count are ignored, so no countdown starts.
- R5: Outside deadline mode, the deadline register reads zero and writes to it are ignored, including writes of a past timestamp.
- R6: In deadline mode, a write of a value greater than the current timestamp stores and arms it. At the edge where the timestamp equals the stored value, a pulse is raised and the register clears to zero. The pulse is visible while the timestamp reads stored value + 1.
- R7: In deadline mode, a write of a nonzero value at or below the current timestamp leaves the register at zero and raises a pulse in the very next cycle.
- R8: In deadline mode, a write of zero disarms the timer and no pulse follows.
- R9: In one-shot mode, a nonzero initial-count write N loads the current count with N. The current count drops by one per clock, and the pulse appears N+1 timestamp ticks after the write edge. The current count then stays at zero and no further pulse follows.
- R10: In periodic mode, the current count reloads from the initial count at each expiry, which gives a pulse every N cycles.
- R11: An initial-count write of zero stops a running countdown in either countdown mode, and no pulse follows.
- R12: With the mask set, expiries still reload or clear state as usual, but `irq_valid` stays low.
- R13: Each pulse lasts one cycle and carries the control vector on `irq_vector`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tsc | input | 64 | Free-running timestamp, +1 per clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq_valid | output | 1 | One-cycle interrupt pulse |
| irq_vector | output | 8 | Vector accompanying the pulse |

## Verification
The hardest cases to reach from the ports are the exact timestamp boundaries of a deadline write. These are a value one tick in the future, which must arm, and a value equal to the current timestamp, which must fire at once. The bench computes each deadline from the timestamp it is driving at the moment of the write, so each case falls exactly on its boundary. It then sends every predicted pulse, tagged with the timestamp it is due at, to a scoreboard. Ignored writes are set up so that honouring them would cause a pulse. A wrongly accepted write would therefore show up as an unexpected pulse.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  localparam int VEC_W     = 8;
  localparam int MASK_BIT  = 16;
  localparam int MODE_LO   = 17;
  localparam int MODE_HI   = 18;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_INIT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CUR  = 2'd2;
  localparam logic [ADDR_W-1:0] A_DL   = 2'd3;

  typedef enum logic [1:0] {
    TM_ONESHOT  = 2'b00,
    TM_PERIODIC = 2'b01,
    TM_DEADLINE = 2'b10,
    TM_RSVD     = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e         mode;
    logic              mask;
    logic [VEC_W-1:0]  vector;
  } tmr_ctrl_t;

endpackage

// File: rtl/dtt_ctrl.sv
module dtt_ctrl
  import dtt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_wr,
  input  logic [MODE_HI:0]      wfield,
  output tmr_ctrl_t             ctrl
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '{mode: TM_ONESHOT, mask: 1'b0, vector: '0};
    end else if (ctrl_wr) begin
      ctrl.mode   <= tmr_mode_e'(wfield[MODE_HI:MODE_LO]);
      ctrl.mask   <= wfield[MASK_BIT];
      ctrl.vector <= wfield[VEC_W-1:0];
    end
  end

endmodule

// File: rtl/dtt_countdown.sv
module dtt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] icr,
  output logic [CNT_W-1:0] ccr,
  output logic             running,
  output logic             expire
);

  function automatic logic at_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic last_tick;
  assign last_tick = running && at_last(ccr);
  assign expire    = last_tick && !clr && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icr     <= '0;
      ccr     <= '0;
      running <= 1'b0;
    end else if (clr) begin
      icr     <= '0;
      ccr     <= '0;
      running <= 1'b0;
    end else if (load) begin
      icr     <= load_val;
      ccr     <= load_val;
      running <= (load_val != '0);
    end else if (running) begin
      if (at_last(ccr)) begin
        if (periodic) begin
          ccr <= icr;
        end else begin
          ccr     <= '0;
          running <= 1'b0;
        end
      end else begin
        ccr <= step(ccr);
      end
    end
  end

endmodule

// File: rtl/dtt_deadline.sv
module dtt_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [TS_W-1:0] load_val,
  input  logic [TS_W-1:0] tsc,
  output logic [TS_W-1:0] dl,
  output logic            armed,
  output logic            hit_fire,
  output logic            imm_fire
);

  function automatic logic is_future(input logic [TS_W-1:0] v,
                                     input logic [TS_W-1:0] now);
    return v > now;
  endfunction

  function automatic logic is_reached(input logic [TS_W-1:0] target,
                                      input logic [TS_W-1:0] now);
    return now >= target;
  endfunction

  logic hit;
  assign hit      = armed && is_reached(dl, tsc);
  assign hit_fire = hit && !clr && !load;
  assign imm_fire = load && !clr && (load_val != '0) && !is_future(load_val, tsc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl    <= '0;
      armed <= 1'b0;
    end else if (clr) begin
      dl    <= '0;
      armed <= 1'b0;
    end else if (load) begin
      if (is_future(load_val, tsc)) begin
        dl    <= load_val;
        armed <= 1'b1;
      end else begin
        dl    <= '0;
        armed <= 1'b0;
      end
    end else if (hit) begin
      dl    <= '0;
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/deadline_tick_timer.sv
module deadline_tick_timer
  import dtt_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   tsc,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [7:0]        irq_vector
);

  tmr_ctrl_t        ctrl;
  logic             ctrl_wr, icr_wr, dl_wr;
  logic             mode_dl, mode_periodic;
  logic [CNT_W-1:0] icr, ccr;
  logic             cd_running, cd_expire;
  logic [TS_W-1:0]  dl;
  logic             dl_armed, dl_hit_fire, dl_imm_fire;
  logic             expire_any, deliver;

  assign ctrl_wr       = reg_wr && (reg_addr == A_CTRL);
  assign mode_dl       = (ctrl.mode == TM_DEADLINE);
  assign mode_periodic = (ctrl.mode == TM_PERIODIC);
  assign icr_wr        = reg_wr && (reg_addr == A_INIT) && !mode_dl;
  assign dl_wr         = reg_wr && (reg_addr == A_DL) && mode_dl;

  dtt_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .wfield (reg_wdata[MODE_HI:0]),
    .ctrl   (ctrl)
  );

  dtt_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl_wr),
    .load    (icr_wr),
    .load_val(reg_wdata[CNT_W-1:0]),
    .periodic(mode_periodic),
    .icr     (icr),
    .ccr     (ccr),
    .running (cd_running),
    .expire  (cd_expire)
  );

  dtt_deadline #(.TS_W(TS_W)) u_dl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl_wr),
    .load    (dl_wr),
    .load_val(reg_wdata[TS_W-1:0]),
    .tsc     (tsc),
    .dl      (dl),
    .armed   (dl_armed),
    .hit_fire(dl_hit_fire),
    .imm_fire(dl_imm_fire)
  );

  assign expire_any = cd_expire || dl_hit_fire || dl_imm_fire;
  assign deliver    = expire_any && !ctrl.mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= deliver;
      irq_vector <= ctrl.vector;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[VEC_W-1:0]       = ctrl.vector;
        reg_rdata[MASK_BIT]        = ctrl.mask;
        reg_rdata[MODE_HI:MODE_LO] = ctrl.mode;
      end
      A_INIT: if (!mode_dl) reg_rdata[CNT_W-1:0] = icr;
      A_CUR:  if (!mode_dl) reg_rdata[CNT_W-1:0] = ccr;
      default: if (mode_dl) reg_rdata[TS_W-1:0] = dl;
    endcase
  end

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int TS_W   = 64,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_valid,
  input logic [7:0]        irq_vector,
  input logic [7:0]        vector,
  input logic              mask,
  input logic [1:0]        mode,
  input logic              ctrl_wr,
  input logic [CNT_W-1:0]  icr,
  input logic [CNT_W-1:0]  ccr,
  input logic [TS_W-1:0]   dl,
  input logic              armed,
  input logic              cd_expire,
  input logic              hit_fire,
  input logic              imm_fire
);

  p_ctrl_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (icr == '0 && ccr == '0 && dl == '0 && !irq_valid));

  p_count_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && (reg_addr == 2'd1 || reg_addr == 2'd2)) |-> reg_rdata == '0);

  p_deadline_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10 && reg_addr == 2'd3) |-> reg_rdata == '0);

  p_self_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (dl == '0 && !armed));

  p_armed_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> dl != '0);

  p_immediate_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_fire && !mask) |=> irq_valid);

  p_oneshot_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_expire && mode == 2'b00) |=> ccr == '0);

  p_periodic_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_expire && mode == 2'b01) |=> ccr == $past(icr));

  p_mask_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask));

  p_vector_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == vector);

endmodule

bind deadline_tick_timer dtt_checker #(.TS_W(TS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_valid (irq_valid),
  .irq_vector(irq_vector),
  .vector    (ctrl.vector),
  .mask      (ctrl.mask),
  .mode      (ctrl.mode),
  .ctrl_wr   (ctrl_wr),
  .icr       (icr),
  .ccr       (ccr),
  .dl        (dl),
  .armed     (dl_armed),
  .cd_expire (cd_expire),
  .hit_fire  (dl_hit_fire),
  .imm_fire  (dl_imm_fire)
);

// File: tb/deadline_tick_timer_bench.sv
module deadline_tick_timer_bench;

  localparam logic [63:0] BASE = 64'h0000_00F0_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tsc;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] wr_t;

  typedef struct { logic [7:0] vec; logic [63:0] ts; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tsc <= BASE;
    else        tsc <= tsc + 64'd1;
  end

  deadline_tick_timer u_deadline_tick_timer (
    .clk(clk), .rst_n(rst_n), .tsc(tsc), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  function automatic logic [63:0] ctl(input logic [1:0] m, input logic msk,
                                      input logic [7:0] v);
    return (64'(m) << 17) | (64'(msk) << 16) | 64'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    wr_t = tsc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [63:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic expect_irq(input logic [7:0] v, input logic [63:0] due, input string tag);
    exp_t e;
    e.vec = v; e.ts = due; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ts(input logic [63:0] t);
    while (tsc != t) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check(sb.size() == 0, tag, 64'(sb.size()), 64'd0);
    sb.delete();
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #1;
    if (rst_n && irq_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R13/R8 unexpected pulse", {56'd0, irq_vector}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(irq_vector == e.vec, {e.tag, " vector"}, {56'd0, irq_vector}, {56'd0, e.vec});
        check(tsc == e.ts, {e.tag, " timing"}, tsc, e.ts);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] t0, d;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq_valid == 1'b0, "R1 irq_valid", {63'd0, irq_valid}, 64'd0);
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 64'd0, "R1 reset read");

    // R2 control field layout
    wr(2'd0, ctl(2'b01, 1'b1, 8'hA5) | 64'h4000_0000);
    rd_chk(2'd0, ctl(2'b01, 1'b1, 8'hA5), "R2 ctrl readback");

    // R9 one-shot
    wr(2'd0, ctl(2'b00, 1'b0, 8'h31));
    wr(2'd1, 64'd5); t0 = wr_t;
    expect_irq(8'h31, t0 + 6, "R9 oneshot");
    rd_chk(2'd2, 64'd5, "R9 ccr loaded");
    idle(12);
    rd_chk(2'd2, 64'd0, "R9 ccr idle");
    rd_chk(2'd1, 64'd5, "R9 icr kept");
    drained("R9 single pulse");

    // R10 periodic, then R3 stop by control write
    wr(2'd0, ctl(2'b01, 1'b0, 8'h42));
    wr(2'd1, 64'd3); t0 = wr_t;
    expect_irq(8'h42, t0 + 4, "R10 period 1");
    expect_irq(8'h42, t0 + 7, "R10 period 2");
    expect_irq(8'h42, t0 + 10, "R10 period 3");
    wait_ts(t0 + 10);
    #2;
    wr(2'd0, ctl(2'b01, 1'b0, 8'h42));
    idle(8);
    drained("R3 stopped after ctrl write");
    rd_chk(2'd1, 64'd0, "R3 icr cleared");
    rd_chk(2'd2, 64'd0, "R3 ccr cleared");

    // R11 zero initial count stops
    wr(2'd0, ctl(2'b01, 1'b0, 8'h43));
    wr(2'd1, 64'd4);
    idle(1);
    wr(2'd1, 64'd0);
    idle(10);
    rd_chk(2'd2, 64'd0, "R11 ccr stopped");
    drained("R11 no pulse");

    // R12 masked periodic still reloads
    wr(2'd0, ctl(2'b01, 1'b1, 8'h55));
    wr(2'd1, 64'd4); t0 = wr_t;
    wait_ts(t0 + 5);
    rd_chk(2'd2, 64'd4, "R12 reload under mask");
    wait_ts(t0 + 6);
    rd_chk(2'd2, 64'd3, "R12 counting under mask");
    idle(10);
    drained("R12 no pulse");

    // R4 deadline mode hides counts, ignores initial count
    wr(2'd0, ctl(2'b10, 1'b0, 8'h66));
    wr(2'd1, 64'd5);
    rd_chk(2'd1, 64'd0, "R4 icr reads zero");
    rd_chk(2'd2, 64'd0, "R4 ccr reads zero");
    idle(10);
    drained("R4 no countdown");

    // R6 future deadline
    d = tsc + 64'd20;
    wr(2'd3, d);
    rd_chk(2'd3, d, "R6 armed value");
    expect_irq(8'h66, d + 1, "R6 deadline fire");
    wait_ts(d + 2);
    rd_chk(2'd3, 64'd0, "R6 self clear");
    drained("R6 drained");

    // R6 boundary: one tick ahead arms
    d = tsc + 64'd1;
    wr(2'd3, d);
    rd_chk(2'd3, d, "R6 boundary armed");
    expect_irq(8'h66, d + 1, "R6 boundary fire");
    idle(3);
    drained("R6 boundary drained");

    // R7 equal and past values fire immediately
    wr(2'd3, tsc); t0 = wr_t;
    expect_irq(8'h66, t0 + 1, "R7 equal fire");
    rd_chk(2'd3, 64'd0, "R7 equal not stored");
    idle(2);
    wr(2'd3, tsc - 64'd100); t0 = wr_t;
    expect_irq(8'h66, t0 + 1, "R7 past fire");
    rd_chk(2'd3, 64'd0, "R7 past not stored");
    idle(3);
    drained("R7 drained");

    // R8 zero disarms
    wr(2'd3, tsc + 64'd10);
    idle(2);
    wr(2'd3, 64'd0);
    idle(15);
    rd_chk(2'd3, 64'd0, "R8 disarmed");
    drained("R8 no pulse");

    // R3 control write clears an armed deadline
    wr(2'd3, tsc + 64'd10);
    wr(2'd0, ctl(2'b10, 1'b0, 8'h67));
    idle(15);
    rd_chk(2'd3, 64'd0, "R3 deadline cleared");
    drained("R3 no deadline pulse");

    // R5 deadline writes ignored outside deadline mode
    wr(2'd0, ctl(2'b00, 1'b0, 8'h70));
    wr(2'd3, tsc + 64'd5);
    rd_chk(2'd3, 64'd0, "R5 reads zero");
    wr(2'd3, tsc - 64'd1);
    idle(10);
    drained("R5 past write ignored");
    wr(2'd0, ctl(2'b10, 1'b0, 8'h70));
    rd_chk(2'd3, 64'd0, "R5 nothing stored");

    idle(5);
    drained("R13 final");
    summary();
  end

endmodule